// File: doc/BRIEF.md
# DMA Channel Destination Address Generator

This block produces the destination address for one DMA channel. Software programs a start address, an address mode and a reload point through a small register write port. The block keeps a working address. Each completed byte moves that address according to the mode: it holds, counts up by one or counts down by one, and it wraps modulo 2^24. When the channel signals the end of the chosen boundary (a block, a burst or the whole transaction), the working address is restored from the start value. The channel engine around the block supplies a busy flag, a byte-done strobe and one strobe for each boundary. It reads the current address back on every cycle.

The block also decodes an 8-bit trigger-select value into a single transfer-request output. The select value is a per-module base plus an offset. The base of module m is (m+1)*16, and the offset, in bits [3:0], picks one of that module's trigger lines. A value of zero disables triggering. A value that names a module that is not fitted, or a line that the module does not have, gives no request.

There is no state machine. The only sequencing is a fixed priority among the updates to the working address, which is taken once per clock.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset the mode field is 00 (hold), the reload field is 00 (never), the start address, the working address and the trigger select are all zero, so `cur_addr` is 0, `trig_req` is 0 and byte-done strobes leave the address at 0.
- R2: With mode 00 or the reserved mode 11, a byte-done strobe while busy leaves `cur_addr` unchanged.
- R3: With mode 01, each byte-done strobe while busy makes `cur_addr` one larger on the next cycle, and 0xFFFFFF wraps to 0x000000.
- R4: With mode 10, each byte-done strobe while busy makes `cur_addr` one smaller on the next cycle, and 0x000000 wraps to 0xFFFFFF.
- R5: The reload field chooses the strobe that restores the working address from the start address while busy: 01 uses `blk_end`, 10 uses `bst_end`, 11 uses `xact_end`, and 00 uses none. The other strobes have no effect on the address.
- R6: When a selected reload strobe and `byte_done` arrive in the same busy cycle, `cur_addr` equals the start address on the next cycle.
- R7: A control write (`wr_sel`=0, mode in `wr_data[1:0]`, reload in `wr_data[3:2]`) made while `busy` is high leaves the mode unchanged but does update the reload field.
- R8: A start-address write (`wr_sel`=1) made while idle loads both the start address and the working address, so `cur_addr` shows the new value on the next cycle. Made while busy, the same write updates only the start address.
- R9: While `busy` is low, `byte_done` and the boundary strobes do not change `cur_addr`.
- R10: While the trigger select (`wr_sel`=2, `wr_data[7:0]`) is zero, `trig_req` stays 0 whatever the trigger lines carry.
- R11: `trig_req` follows `trig_in[m*4+o]` combinationally when the select equals (m+1)*16+o, where module m is fitted (modules 0, 1 and 3 by default) and o < 4. Every other nonzero select holds `trig_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 start address, 2 trigger select, 3 none |
| wr_data | input | 24 | Write data |
| busy | input | 1 | Channel is transferring |
| byte_done | input | 1 | One byte moved in this cycle |
| blk_end | input | 1 | End of a block |
| bst_end | input | 1 | End of a burst |
| xact_end | input | 1 | End of the transaction |
| trig_in | input | 16 | Trigger lines, 4 per module slot |
| cur_addr | output | 24 | Current destination address |
| trig_req | output | 1 | Decoded transfer request |

## Verification
A wrong mode or reload setting, or a corrupted start address, stays hidden until the next busy byte-done or boundary strobe. From that strobe on, `cur_addr` is wrong on the very next cycle and stays off through all later steps. The bench therefore compares `cur_addr` against a behavioural model after every clock, so a fault shows up at the first update that uses the bad state. A lock on the mode field that should reject a write but accepts it appears only as a wrong step direction. Each busy-write case is therefore followed at once by a byte-done step. A wrong trigger decode shows immediately on `trig_req`, which is combinational, and is checked for every one of the 256 select values.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    typedef enum logic [1:0] {
        AM_HOLD = 2'b00,
        AM_UP   = 2'b01,
        AM_DOWN = 2'b10,
        AM_RSVD = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        RL_NEVER = 2'b00,
        RL_BLOCK = 2'b01,
        RL_BURST = 2'b10,
        RL_XACT  = 2'b11
    } reload_pt_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_START = 2'd1,
        REG_TSEL  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int TSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              busy,
    output addr_mode_e        mode_o,
    output reload_pt_e        reload_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [TSEL_W-1:0] tsel_o
);

    logic ctrl_wr, start_wr, tsel_wr;

    always_comb begin
        ctrl_wr  = wr_en && (reg_sel_e'(wr_sel) == REG_CTRL);
        start_wr = wr_en && (reg_sel_e'(wr_sel) == REG_START);
        tsel_wr  = wr_en && (reg_sel_e'(wr_sel) == REG_TSEL);
    end

    // mode field is frozen while the channel runs; reload field is not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o   <= AM_HOLD;
            reload_o <= RL_NEVER;
        end else if (ctrl_wr) begin
            reload_o <= reload_pt_e'(wr_data[3:2]);
            if (!busy) begin
                mode_o <= addr_mode_e'(wr_data[1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= '0;
        end else if (start_wr) begin
            start_o <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsel_o <= '0;
        end else if (tsel_wr) begin
            tsel_o <= wr_data[TSEL_W-1:0];
        end
    end

endmodule

// File: rtl/dma_trig_decode.sv
module dma_trig_decode #(
    parameter int          N_MOD        = 4,
    parameter int          TRIG_PER_MOD = 4,
    parameter int unsigned MOD_PRESENT  = 32'b1011,
    localparam int         N_TRIG       = N_MOD * TRIG_PER_MOD
) (
    input  logic [7:0]        tsel,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              req
);

    logic [N_TRIG-1:0] line_hit;

    // module m answers at base (m+1)*16; code zero can never match
    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        localparam bit FITTED = ((MOD_PRESENT >> m) & 1) != 0;
        for (genvar o = 0; o < TRIG_PER_MOD; o++) begin : g_line
            localparam logic [7:0] CODE = 8'(((m + 1) * 16) + o);
            if (FITTED) begin : g_fit
                assign line_hit[m*TRIG_PER_MOD+o] =
                    (tsel == CODE) && trig_in[m*TRIG_PER_MOD+o];
            end else begin : g_absent
                assign line_hit[m*TRIG_PER_MOD+o] = 1'b0;
            end
        end
    end

    assign req = |line_hit;

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] nxt
);

    always_comb begin
        unique case (mode)
            AM_UP:   nxt = cur + ADDR_W'(1);
            AM_DOWN: nxt = cur - ADDR_W'(1);
            AM_HOLD,
            AM_RSVD: nxt = cur;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int          ADDR_W       = 24,
    parameter int          N_MOD        = 4,
    parameter int          TRIG_PER_MOD = 4,
    parameter int unsigned MOD_PRESENT  = 32'b1011,
    localparam int         N_TRIG       = N_MOD * TRIG_PER_MOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              busy,
    input  logic              byte_done,
    input  logic              blk_end,
    input  logic              bst_end,
    input  logic              xact_end,
    input  logic [N_TRIG-1:0] trig_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              trig_req
);

    addr_mode_e        mode_q;
    reload_pt_e        reload_q;
    logic [ADDR_W-1:0] start_q;
    logic [7:0]        tsel_q;
    logic [ADDR_W-1:0] work_q;
    logic [ADDR_W-1:0] step_nxt;
    logic              rl_hit;
    logic              start_ld;

    dma_cfg_regs #(
        .ADDR_W (ADDR_W),
        .TSEL_W (8)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .busy     (busy),
        .mode_o   (mode_q),
        .reload_o (reload_q),
        .start_o  (start_q),
        .tsel_o   (tsel_q)
    );

    dma_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .cur  (work_q),
        .mode (mode_q),
        .nxt  (step_nxt)
    );

    dma_trig_decode #(
        .N_MOD        (N_MOD),
        .TRIG_PER_MOD (TRIG_PER_MOD),
        .MOD_PRESENT  (MOD_PRESENT)
    ) u_trig (
        .tsel    (tsel_q),
        .trig_in (trig_in),
        .req     (trig_req)
    );

    always_comb begin
        unique case (reload_q)
            RL_BLOCK: rl_hit = blk_end;
            RL_BURST: rl_hit = bst_end;
            RL_XACT:  rl_hit = xact_end;
            RL_NEVER: rl_hit = 1'b0;
            default:  rl_hit = 1'b0;
        endcase
        start_ld = wr_en && (reg_sel_e'(wr_sel) == REG_START) && !busy;
    end

    // priority: idle start load, then reload, then byte step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (start_ld) begin
            work_q <= wr_data;
        end else if (busy && rl_hit) begin
            work_q <= start_q;
        end else if (busy && byte_done) begin
            work_q <= step_nxt;
        end
    end

    assign cur_addr = work_q;

endmodule

// File: rtl/dma_dst_addr_gen_chk.sv
module dma_dst_addr_gen_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic              busy,
    input logic              byte_done,
    input logic              blk_end,
    input logic              bst_end,
    input logic              xact_end,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              trig_req,
    input logic [1:0]        mode,
    input logic [1:0]        reload,
    input logic [ADDR_W-1:0] start,
    input logic [7:0]        tsel
);

    logic ld_idle;
    logic sel_strobe;

    always_comb begin
        ld_idle    = wr_en && (wr_sel == 2'd1) && !busy;
        sel_strobe = (reload == 2'd1 && blk_end) || (reload == 2'd2 && bst_end)
                  || (reload == 2'd3 && xact_end);
    end

    p_zero_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel == 8'd0) |-> !trig_req);

    p_mode_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mode == $past(mode)));

    p_reload_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_strobe) |=> (cur_addr == $past(start)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && !sel_strobe && (mode == 2'd0 || mode == 2'd3))
        |=> $stable(cur_addr));

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && !sel_strobe && mode == 2'd1)
        |=> (cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1))));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_done && !sel_strobe && mode == 2'd2)
        |=> (cur_addr == ADDR_W'($past(cur_addr) - ADDR_W'(1))));

    p_idle_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_idle) |=> $stable(cur_addr));

    p_idle_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_idle |=> (cur_addr == $past(wr_data)));

endmodule

bind dma_dst_addr_gen dma_dst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .busy      (busy),
    .byte_done (byte_done),
    .blk_end   (blk_end),
    .bst_end   (bst_end),
    .xact_end  (xact_end),
    .cur_addr  (cur_addr),
    .trig_req  (trig_req),
    .mode      (mode_q),
    .reload    (reload_q),
    .start     (start_q),
    .tsel      (tsel_q)
);

// File: tb/dma_dst_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_dst_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [23:0] wr_data = 24'd0;
    logic        busy = 1'b0;
    logic        byte_done = 1'b0;
    logic        blk_end = 1'b0;
    logic        bst_end = 1'b0;
    logic        xact_end = 1'b0;
    logic [15:0] trig_in = 16'd0;
    logic [23:0] cur_addr;
    logic        trig_req;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    logic [1:0]  m_mode = 2'd0;
    logic [1:0]  m_rel = 2'd0;
    logic [23:0] m_start = 24'd0;
    logic [23:0] m_work = 24'd0;
    logic [7:0]  m_tsel = 8'd0;

    always #2.5 clk = ~clk;

    dma_dst_addr_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .busy      (busy),
        .byte_done (byte_done),
        .blk_end   (blk_end),
        .bst_end   (bst_end),
        .xact_end  (xact_end),
        .trig_in   (trig_in),
        .cur_addr  (cur_addr),
        .trig_req  (trig_req)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %06h expected %06h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_trig(input logic [7:0] s, input logic [15:0] ti);
        int m, o;
        m = int'(s[7:4]) - 1;
        o = int'(s[3:0]);
        if (s == 8'd0) return 1'b0;
        if (m < 0 || m > 3 || m == 2 || o > 3) return 1'b0;
        return ti[m*4+o];
    endfunction

    // one clock: drive at negedge, check request, update model, check address
    task automatic cyc(input bit we, input logic [1:0] ws, input logic [23:0] wd,
                       input bit b, input bit bd, input bit be, input bit se,
                       input bit xe, input logic [15:0] ti, input string tag_in);
        string tag;
        string ttag;
        logic  hit;
        hit = (m_rel == 2'd1 && be) || (m_rel == 2'd2 && se) || (m_rel == 2'd3 && xe);
        tag = tag_in;
        if (tag == "") begin
            if (we && ws == 2'd1 && !b) tag = "R8";
            else if (!b) tag = "R9";
            else if (hit) tag = bd ? "R6" : "R5";
            else if (bd) tag = (m_mode == 2'd1) ? "R3" : (m_mode == 2'd2) ? "R4" : "R2";
            else tag = "R7";
        end
        wr_en = we; wr_sel = ws; wr_data = wd; busy = b; byte_done = bd;
        blk_end = be; bst_end = se; xact_end = xe; trig_in = ti;
        #1;
        ttag = (m_tsel == 8'd0) ? "R10" : "R11";
        chk(ttag, {23'd0, trig_req}, {23'd0, exp_trig(m_tsel, ti)});
        @(posedge clk);
        if (we && ws == 2'd1 && !b) m_work = wd;
        else if (b && hit) m_work = m_start;
        else if (b && bd) begin
            if (m_mode == 2'd1) m_work = m_work + 24'd1;
            else if (m_mode == 2'd2) m_work = m_work - 24'd1;
        end
        if (we) begin
            case (ws)
                2'd0: begin
                    m_rel = wd[3:2];
                    if (!b) m_mode = wd[1:0];
                end
                2'd1: m_start = wd;
                2'd2: m_tsel = wd[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
        chk(tag, cur_addr, m_work);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [23:0] wd, input bit b, input string tag);
        cyc(1'b1, ws, wd, b, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, tag);
    endtask

    task automatic run(input bit bd, input bit be, input bit se, input bit xe, input string tag);
        cyc(1'b0, 2'd3, 24'd0, 1'b1, bd, be, se, xe, 16'd0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        trig_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", cur_addr, 24'd0);
        chk("R1", {23'd0, trig_req}, 24'd0);
        @(negedge clk);
        run(1, 0, 0, 0, "R1");
        run(1, 1, 1, 1, "R1");

        // R3 increment and wrap
        wr(2'd1, 24'hFFFFFE, 0, "R8");
        wr(2'd0, 24'h000001, 0, "R3");
        run(1, 0, 0, 0, "R3");
        run(1, 0, 0, 0, "R3");
        run(1, 0, 0, 0, "R3");

        // R4 decrement and wrap
        wr(2'd0, 24'h000002, 0, "R4");
        wr(2'd1, 24'h000001, 0, "R8");
        run(1, 0, 0, 0, "R4");
        run(1, 0, 0, 0, "R4");
        run(1, 0, 0, 0, "R4");

        // R2 reserved and fixed
        wr(2'd0, 24'h000003, 0, "R2");
        run(1, 0, 0, 0, "R2");
        run(1, 0, 0, 0, "R2");
        wr(2'd0, 24'h000000, 0, "R2");
        run(1, 0, 0, 0, "R2");

        // R7 mode locked while busy, reload accepted
        wr(2'd1, 24'h000040, 0, "R8");
        wr(2'd0, 24'h000002, 0, "R7");
        wr(2'd0, 24'h000005, 1, "R7");
        run(1, 0, 0, 0, "R7");
        run(1, 0, 0, 0, "R7");
        run(0, 1, 0, 0, "R7");

        // R5 each reload point
        for (int rl = 0; rl < 4; rl++) begin
            wr(2'd0, 24'(rl * 4 + 1), 0, "R5");
            wr(2'd1, 24'h000100, 0, "R8");
            run(1, 0, 0, 0, "R5");
            run(1, 0, 0, 0, "R5");
            run(0, rl != 1, rl != 2, rl != 3, "R5");
            run(0, rl == 1, rl == 2, rl == 3, "R5");
            // R6 reload and step together
            run(1, 0, 0, 0, "R6");
            run(1, 1, 1, 1, "R6");
        end

        // R9 strobes while idle
        wr(2'd0, 24'h000005, 0, "R9");
        run(1, 0, 0, 0, "R9");
        cyc(0, 2'd3, 24'd0, 0, 1, 1, 1, 1, 16'd0, "R9");
        cyc(0, 2'd0, 24'd0, 0, 1, 0, 0, 0, 16'd0, "R9");

        // R8 start write while busy
        cyc(1, 2'd1, 24'hABCDEF, 1, 0, 0, 0, 0, 16'd0, "R8");
        run(1, 0, 0, 0, "R8");
        run(0, 1, 0, 0, "R8");

        // R10 zero select, R11 every select value
        wr(2'd2, 24'h000000, 0, "R10");
        cyc(0, 2'd3, 24'd0, 0, 0, 0, 0, 0, 16'hFFFF, "R10");
        for (int s = 0; s < 256; s++) begin
            wr(2'd2, 24'(s), 0, "R11");
            cyc(0, 2'd3, 24'd0, 0, 0, 0, 0, 0, 16'hFFFF, "R11");
            cyc(0, 2'd3, 24'd0, 0, 0, 0, 0, 0, 16'h0000, "R11");
            cyc(0, 2'd3, 24'd0, 0, 0, 0, 0, 0, 16'($urandom), "R11");
        end

        // mixed traffic with automatic tags
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [23:0] d;
            r = $urandom;
            d = r[4] ? 24'($urandom) : {r[5] ? 20'hFFFFF : 20'h00000, 4'($urandom)};
            cyc(r[0] & r[1], r[3:2], d, r[6] | r[7], r[8] | r[9], r[10] & r[11],
                r[12] & r[13], r[14] & r[15], 16'($urandom), "");
        end

        report();
        $finish;
    end

endmodule